// File: doc/BRIEF.md
# Indirect Data Address Generator

This block forms the data-space address for every load and store of a small 8-bit core. Three 16-bit pointers, called X, Y and Z, are held as byte pairs in the top six of the 32 working registers. The register file presents them to this block as three 16-bit values. A one-cycle start strobe carries a pointer select, an addressing mode, a 6-bit displacement, a 16-bit direct address and a store flag.

One cycle later the block presents a registered result. The result holds the effective address and the data-space region the address falls in. For an I/O address it also gives the I/O register index. It carries flags for an out-of-range SRAM address and for an illegal request, plus a write permission for stores. When the mode changes the pointer, it also gives a pointer write-back value, the index of the register that receives the low byte, and a write-back enable.

The data space is laid out from address 0 upward in three parts: the 32 working registers, then 64 I/O registers, then the internal SRAM. Every access occupies two cycles: the start cycle and the result cycle.

Top module: `ind_addr_gen`

## Requirements
- R1: Plain indirect mode (mode code 0) uses the selected pointer (select code 0 = X, 1 = Y, 2 = Z) as the address and requests no pointer write-back.
- R2: Post-increment mode (mode code 1) uses the unmodified pointer as the address and writes back the pointer plus one, modulo 2^16.
- R3: Pre-decrement mode (mode code 2) subtracts one from the pointer, modulo 2^16, and uses the result both as the address and as the write-back value.
- R4: Displacement mode (mode code 3) adds the zero-extended 6-bit displacement to the Y or Z pointer and requests no write-back.
- R5: Direct mode (mode code 4) uses the 16-bit direct address input, ignores the pointer select (including code 3) and requests no write-back.
- R6: An illegal request raises `illegal`, forces the address to 0 and the region to code 3, and asserts neither `wb_en` nor `wr_en`. Three requests are illegal: displacement mode with X, pointer select code 3 in any mode other than direct, and mode codes 5 to 7.
- R7: Region codes are 0 for addresses 0x00 to 0x1F (registers) and 1 for 0x20 to 0x5F (I/O), where `io_idx` equals the address minus 0x20. Code 2 covers 0x60 to the SRAM top, which is 0x15F with the default 256-byte SRAM. `io_idx` is 0 outside the I/O region.
- R8: An address above the SRAM top gives region code 3 and raises `out_of_range`. A pointer write-back requested by the mode still takes place.
- R9: `wb_idx` names the even register that receives the pointer's low byte: 26 for X, 28 for Y, 30 for Z. The high byte goes to the next register up.
- R10: The result appears, with `acc_vld` high, in the cycle after the clock edge that samples `start` high. `acc_vld` lasts one cycle. A start seen while `acc_vld` is high is ignored, and the result fields hold until the next accepted start.
- R11: After reset, `acc_vld`, `wb_en`, `wr_en`, `out_of_range` and `illegal` are 0, the address is 0 and the region code is 0.
- R12: `wr_en` pulses with `acc_vld` only for a store whose request is legal and whose address is in range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| mode | input | 3 | Addressing mode code |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Address for direct mode |
| is_store | input | 1 | Request is a store |
| x_ptr | input | 16 | X pointer from registers 27:26 |
| y_ptr | input | 16 | Y pointer from registers 29:28 |
| z_ptr | input | 16 | Z pointer from registers 31:30 |
| acc_vld | output | 1 | Result valid, one cycle |
| eff_addr | output | 16 | Effective data-space address |
| region | output | 2 | 0 register, 1 I/O, 2 SRAM, 3 none |
| io_idx | output | 6 | I/O register index |
| out_of_range | output | 1 | Address beyond SRAM top |
| illegal | output | 1 | Request not supported |
| wr_en | output | 1 | Store may be performed |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Register index of write-back low byte |
| wb_val | output | 16 | Updated pointer value |

## Verification
Each mode is driven with each legal pointer. The pointer values are chosen at region edges (0x1F, 0x60, 0x15F), so an error of one in the increment or decrement moves the result into a different region and is caught by the region check as well as the address check. Wrap-around cases, with Z at 0xFFFF post-incremented and Y at 0 pre-decremented, separate modulo arithmetic from saturation. They also show that write-back continues while `out_of_range` blocks the store. The illegal combinations, a start during the result cycle, and a reset in the middle of a run confirm the rejection, busy and reset behaviour.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [1:0] PSEL_X = 2'd0;
  localparam logic [1:0] PSEL_Y = 2'd1;
  localparam logic [1:0] PSEL_Z = 2'd2;

  localparam logic [2:0] AM_PLAIN   = 3'd0;
  localparam logic [2:0] AM_POSTINC = 3'd1;
  localparam logic [2:0] AM_PREDEC  = 3'd2;
  localparam logic [2:0] AM_DISP    = 3'd3;
  localparam logic [2:0] AM_DIRECT  = 3'd4;

  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int AW   = 16,
  parameter int NREG = 32
) (
  input  logic [1:0]              sel,
  input  logic [AW-1:0]           x_ptr,
  input  logic [AW-1:0]           y_ptr,
  input  logic [AW-1:0]           z_ptr,
  output logic [AW-1:0]           ptr,
  output logic [$clog2(NREG)-1:0] lo_idx,
  output logic                    sel_ok
);
  localparam int NPTR     = 3;
  localparam int IDXW     = $clog2(NREG);
  localparam int FIRST_LO = NREG - 2 * NPTR;

  logic [IDXW-1:0] idx_tab [NPTR];

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_idx
      assign idx_tab[g] = IDXW'(FIRST_LO + 2 * g);
    end
  endgenerate

  always_comb begin
    sel_ok = 1'b1;
    ptr    = '0;
    lo_idx = '0;
    case (sel)
      agu_pkg::PSEL_X: begin ptr = x_ptr; lo_idx = idx_tab[0]; end
      agu_pkg::PSEL_Y: begin ptr = y_ptr; lo_idx = idx_tab[1]; end
      agu_pkg::PSEL_Z: begin ptr = z_ptr; lo_idx = idx_tab[2]; end
      default:         sel_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    sel,
  input  logic          sel_ok,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] direct_addr,
  output logic [AW-1:0] addr,
  output logic          wb_need,
  output logic [AW-1:0] wb_val,
  output logic          legal
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_off;

  assign ptr_inc = ptr + AW'(1);
  assign ptr_dec = ptr - AW'(1);
  assign ptr_off = ptr + AW'(disp);

  always_comb begin
    addr    = '0;
    wb_need = 1'b0;
    wb_val  = ptr;
    legal   = sel_ok;
    case (mode)
      AM_PLAIN:   addr = ptr;
      AM_POSTINC: begin addr = ptr;     wb_val = ptr_inc; wb_need = 1'b1; end
      AM_PREDEC:  begin addr = ptr_dec; wb_val = ptr_dec; wb_need = 1'b1; end
      AM_DISP:    begin addr = ptr_off; legal = sel_ok && (sel != PSEL_X); end
      AM_DIRECT:  begin addr = direct_addr; legal = 1'b1; end
      default:    legal = 1'b0;
    endcase
    if (!legal) begin
      addr    = '0;
      wb_need = 1'b0;
    end
  end
endmodule

// File: rtl/agu_region.sv
module agu_region #(
  parameter int AW         = 16,
  parameter int NREG       = 32,
  parameter int NIO        = 64,
  parameter int SRAM_BYTES = 256
) (
  input  logic [AW-1:0]          addr,
  output agu_pkg::region_e       region,
  output logic [$clog2(NIO)-1:0] io_idx,
  output logic                   oor
);
  localparam int IOW = $clog2(NIO);
  localparam logic [AW-1:0] IO_LO   = AW'(NREG);
  localparam logic [AW-1:0] SRAM_LO = AW'(NREG + NIO);
  localparam logic [AW-1:0] SRAM_HI = AW'(NREG + NIO + SRAM_BYTES - 1);

  always_comb begin
    io_idx = '0;
    oor    = 1'b0;
    if (addr < IO_LO) begin
      region = agu_pkg::RGN_REG;
    end else if (addr < SRAM_LO) begin
      region = agu_pkg::RGN_IO;
      io_idx = IOW'(addr - IO_LO);
    end else if (addr <= SRAM_HI) begin
      region = agu_pkg::RGN_SRAM;
    end else begin
      region = agu_pkg::RGN_NONE;
      oor    = 1'b1;
    end
  end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
  parameter int AW         = 16,
  parameter int DW         = 6,
  parameter int NREG       = 32,
  parameter int NIO        = 64,
  parameter int SRAM_BYTES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              ptr_sel,
  input  logic [2:0]              mode,
  input  logic [DW-1:0]           disp,
  input  logic [AW-1:0]           direct_addr,
  input  logic                    is_store,
  input  logic [AW-1:0]           x_ptr,
  input  logic [AW-1:0]           y_ptr,
  input  logic [AW-1:0]           z_ptr,
  output logic                    acc_vld,
  output logic [AW-1:0]           eff_addr,
  output logic [1:0]              region,
  output logic [$clog2(NIO)-1:0]  io_idx,
  output logic                    out_of_range,
  output logic                    illegal,
  output logic                    wr_en,
  output logic                    wb_en,
  output logic [$clog2(NREG)-1:0] wb_idx,
  output logic [AW-1:0]           wb_val
);
  localparam int IOW  = $clog2(NIO);
  localparam int IDXW = $clog2(NREG);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // combinational address path
  logic [AW-1:0]     sel_ptr;
  logic [IDXW-1:0]   sel_lo_idx;
  logic              sel_ok;
  logic [AW-1:0]     calc_addr;
  logic              calc_wb_need;
  logic [AW-1:0]     calc_wb_val;
  logic              calc_legal;
  agu_pkg::region_e  dec_region;
  logic [IOW-1:0]    dec_io_idx;
  logic              dec_oor;

  agu_ptr_mux #(.AW(AW), .NREG(NREG)) u_ptr_mux (
    .sel    (ptr_sel),
    .x_ptr  (x_ptr),
    .y_ptr  (y_ptr),
    .z_ptr  (z_ptr),
    .ptr    (sel_ptr),
    .lo_idx (sel_lo_idx),
    .sel_ok (sel_ok)
  );

  agu_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode        (mode),
    .sel         (ptr_sel),
    .sel_ok      (sel_ok),
    .ptr         (sel_ptr),
    .disp        (disp),
    .direct_addr (direct_addr),
    .addr        (calc_addr),
    .wb_need     (calc_wb_need),
    .wb_val      (calc_wb_val),
    .legal       (calc_legal)
  );

  agu_region #(.AW(AW), .NREG(NREG), .NIO(NIO), .SRAM_BYTES(SRAM_BYTES)) u_region (
    .addr   (calc_addr),
    .region (dec_region),
    .io_idx (dec_io_idx),
    .oor    (dec_oor)
  );

  // result register: next state
  logic            cap_en;
  logic            vld_q,  vld_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [1:0]      rgn_q,  rgn_d;
  logic [IOW-1:0]  io_q,   io_d;
  logic            oor_q,  oor_d;
  logic            ill_q,  ill_d;
  logic            wr_q,   wr_d;
  logic            wb_q,   wb_d;
  logic [IDXW-1:0] wbi_q,  wbi_d;
  logic [AW-1:0]   wbv_q,  wbv_d;

  assign cap_en = start && !vld_q;

  always_comb begin
    vld_d  = cap_en;
    wr_d   = 1'b0;
    wb_d   = 1'b0;
    addr_d = addr_q;
    rgn_d  = rgn_q;
    io_d   = io_q;
    oor_d  = oor_q;
    ill_d  = ill_q;
    wbi_d  = wbi_q;
    wbv_d  = wbv_q;
    if (cap_en) begin
      ill_d  = !calc_legal;
      addr_d = calc_addr;
      wb_d   = calc_wb_need;
      wbi_d  = calc_wb_need ? sel_lo_idx : '0;
      wbv_d  = calc_wb_val;
      if (calc_legal) begin
        rgn_d = dec_region;
        io_d  = dec_io_idx;
        oor_d = dec_oor;
        wr_d  = is_store && !dec_oor;
      end else begin
        rgn_d = agu_pkg::RGN_NONE;
        io_d  = '0;
        oor_d = 1'b0;
      end
    end
  end

  // result register: state
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      rgn_q  <= 2'd0;
      io_q   <= '0;
      oor_q  <= 1'b0;
      ill_q  <= 1'b0;
      wr_q   <= 1'b0;
      wb_q   <= 1'b0;
      wbi_q  <= '0;
      wbv_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      rgn_q  <= rgn_d;
      io_q   <= io_d;
      oor_q  <= oor_d;
      ill_q  <= ill_d;
      wr_q   <= wr_d;
      wb_q   <= wb_d;
      wbi_q  <= wbi_d;
      wbv_q  <= wbv_d;
    end
  end

  assign acc_vld      = vld_q;
  assign eff_addr     = addr_q;
  assign region       = rgn_q;
  assign io_idx       = io_q;
  assign out_of_range = oor_q;
  assign illegal      = ill_q;
  assign wr_en        = wr_q;
  assign wb_en        = wb_q;
  assign wb_idx       = wbi_q;
  assign wb_val       = wbv_q;
endmodule

// File: rtl/ind_addr_gen_chk.sv
module ind_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        acc_vld,
  input logic [15:0] eff_addr,
  input logic [1:0]  region,
  input logic        out_of_range,
  input logic        illegal,
  input logic        wr_en,
  input logic        wb_en
);
  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> !acc_vld);

  // R10
  start_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !acc_vld) |=> acc_vld);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> $stable(eff_addr));

  // R8
  oor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> !wr_en);

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !wb_en && region == 2'd3));

  // R2
  wb_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || wr_en) |-> acc_vld);

  // R7
  io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd1) |-> (eff_addr >= 16'h0020 && eff_addr < 16'h0060));
endmodule

bind ind_addr_gen ind_addr_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start        (start),
  .acc_vld      (acc_vld),
  .eff_addr     (eff_addr),
  .region       (region),
  .out_of_range (out_of_range),
  .illegal      (illegal),
  .wr_en        (wr_en),
  .wb_en        (wb_en)
);

// File: tb/ind_addr_gen_bench.sv
`timescale 1ns/1ps
module ind_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  ptr_sel;
  logic [2:0]  mode;
  logic [5:0]  disp;
  logic [15:0] direct_addr;
  logic        is_store;
  logic [15:0] x_ptr, y_ptr, z_ptr;
  logic        acc_vld;
  logic [15:0] eff_addr;
  logic [1:0]  region;
  logic [5:0]  io_idx;
  logic        out_of_range, illegal, wr_en, wb_en;
  logic [4:0]  wb_idx;
  logic [15:0] wb_val;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ind_addr_gen u_ind_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_sel(ptr_sel), .mode(mode),
    .disp(disp), .direct_addr(direct_addr), .is_store(is_store),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr),
    .acc_vld(acc_vld), .eff_addr(eff_addr), .region(region), .io_idx(io_idx),
    .out_of_range(out_of_range), .illegal(illegal), .wr_en(wr_en),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  mode;
    logic [5:0]  disp;
    logic [15:0] dir;
    logic        st;
    logic [15:0] e_addr;
    logic [1:0]  e_rgn;
    logic [5:0]  e_io;
    logic        e_oor;
    logic        e_ill;
    logic        e_wb;
    logic [15:0] e_wbv;
    logic        e_wr;
  } vec_t;

  // pointers for the table: X=0x001F, Y=0x0060, Z=0x015F
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    {2'd0,3'd0,6'd0, 16'h0000,1'b1, 16'h001F,2'd0,6'd0, 1'b0,1'b0,1'b0,16'h0000,1'b1},
    {2'd0,3'd1,6'd0, 16'h0000,1'b0, 16'h001F,2'd0,6'd0, 1'b0,1'b0,1'b1,16'h0020,1'b0},
    {2'd0,3'd2,6'd0, 16'h0000,1'b1, 16'h001E,2'd0,6'd0, 1'b0,1'b0,1'b1,16'h001E,1'b1},
    {2'd1,3'd0,6'd0, 16'h0000,1'b0, 16'h0060,2'd2,6'd0, 1'b0,1'b0,1'b0,16'h0000,1'b0},
    {2'd1,3'd2,6'd0, 16'h0000,1'b1, 16'h005F,2'd1,6'h3F,1'b0,1'b0,1'b1,16'h005F,1'b1},
    {2'd1,3'd3,6'd63,16'h0000,1'b1, 16'h009F,2'd2,6'd0, 1'b0,1'b0,1'b0,16'h0000,1'b1},
    {2'd2,3'd1,6'd0, 16'h0000,1'b1, 16'h015F,2'd2,6'd0, 1'b0,1'b0,1'b1,16'h0160,1'b1},
    {2'd2,3'd3,6'd1, 16'h0000,1'b1, 16'h0160,2'd3,6'd0, 1'b1,1'b0,1'b0,16'h0000,1'b0},
    {2'd0,3'd3,6'd5, 16'h0000,1'b1, 16'h0000,2'd3,6'd0, 1'b0,1'b1,1'b0,16'h0000,1'b0},
    {2'd3,3'd4,6'd0, 16'h0020,1'b1, 16'h0020,2'd1,6'd0, 1'b0,1'b0,1'b0,16'h0000,1'b1},
    {2'd1,3'd4,6'd0, 16'hFFFF,1'b1, 16'hFFFF,2'd3,6'd0, 1'b1,1'b0,1'b0,16'h0000,1'b0},
    {2'd3,3'd0,6'd0, 16'h0000,1'b1, 16'h0000,2'd3,6'd0, 1'b0,1'b1,1'b0,16'h0000,1'b0},
    {2'd2,3'd5,6'd0, 16'h0000,1'b1, 16'h0000,2'd3,6'd0, 1'b0,1'b1,1'b0,16'h0000,1'b0},
    {2'd2,3'd2,6'd0, 16'h0000,1'b0, 16'h015E,2'd2,6'd0, 1'b0,1'b0,1'b1,16'h015E,1'b0}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one request: drive after negedge, sample at the negedge after the capture edge
  task automatic issue(input logic [1:0] s, input logic [2:0] m, input logic [5:0] d,
                       input logic [15:0] da, input logic st);
    ptr_sel = s; mode = m; disp = d; direct_addr = da; is_store = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    chk(tag, "acc_vld",  32'(acc_vld), 32'd0);
    chk(tag, "wb_en",    32'(wb_en), 32'd0);
    chk(tag, "wr_en",    32'(wr_en), 32'd0);
    chk(tag, "oor",      32'(out_of_range), 32'd0);
    chk(tag, "illegal",  32'(illegal), 32'd0);
    chk(tag, "eff_addr", 32'(eff_addr), 32'd0);
    chk(tag, "region",   32'(region), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ptr_sel = '0; mode = '0; disp = '0;
    direct_addr = '0; is_store = 1'b0;
    x_ptr = 16'h001F; y_ptr = 16'h0060; z_ptr = 16'h015F;
    repeat (3) @(negedge clk);
    check_reset_state("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(VT[i].sel, VT[i].mode, VT[i].disp, VT[i].dir, VT[i].st);
      chk("R10", "acc_vld", 32'(acc_vld), 32'd1);
      chk(mode_tag(VT[i].mode), "eff_addr", 32'(eff_addr), 32'(VT[i].e_addr));
      chk("R7",  "region",   32'(region), 32'(VT[i].e_rgn));
      chk("R7",  "io_idx",   32'(io_idx), 32'(VT[i].e_io));
      chk("R8",  "oor",      32'(out_of_range), 32'(VT[i].e_oor));
      chk("R6",  "illegal",  32'(illegal), 32'(VT[i].e_ill));
      chk(mode_tag(VT[i].mode), "wb_en", 32'(wb_en), 32'(VT[i].e_wb));
      chk("R12", "wr_en",    32'(wr_en), 32'(VT[i].e_wr));
      if (VT[i].e_wb) begin
        chk(mode_tag(VT[i].mode), "wb_val", 32'(wb_val), 32'(VT[i].e_wbv));
        chk("R9", "wb_idx", 32'(wb_idx), 32'(5'd26 + 5'(VT[i].sel) * 5'd2));
      end
      @(negedge clk);
      chk("R10", "acc_vld pulse", 32'(acc_vld), 32'd0);
    end

    // R2 and R8: wrap on post-increment from 0xFFFF, write-back still done
    z_ptr = 16'hFFFF;
    issue(2'd2, 3'd1, 6'd0, 16'h0, 1'b1);
    chk("R2", "wrap addr", 32'(eff_addr), 32'h0000FFFF);
    chk("R2", "wrap wb_val", 32'(wb_val), 32'h00000000);
    chk("R8", "wrap wb_en", 32'(wb_en), 32'd1);
    chk("R8", "wrap wr_en", 32'(wr_en), 32'd0);
    @(negedge clk);

    // R3: wrap on pre-decrement from 0
    y_ptr = 16'h0000;
    issue(2'd1, 3'd2, 6'd0, 16'h0, 1'b1);
    chk("R3", "wrap addr", 32'(eff_addr), 32'h0000FFFF);
    chk("R3", "wrap wb_val", 32'(wb_val), 32'h0000FFFF);
    chk("R9", "wrap wb_idx", 32'(wb_idx), 32'd28);
    chk("R8", "wrap oor", 32'(out_of_range), 32'd1);
    @(negedge clk);

    // R10: start during the result cycle is ignored
    y_ptr = 16'h0060;
    issue(2'd1, 3'd0, 6'd0, 16'h0, 1'b0);
    ptr_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    chk("R10", "busy start ignored vld", 32'(acc_vld), 32'd0);
    chk("R10", "busy start ignored addr", 32'(eff_addr), 32'h00000060);
    @(negedge clk);
    start = 1'b0;
    chk("R10", "retry accepted", 32'(eff_addr), 32'h0000001F);
    repeat (3) @(negedge clk);
    chk("R10", "hold addr", 32'(eff_addr), 32'h0000001F);
    chk("R10", "hold vld", 32'(acc_vld), 32'd0);

    // R11: reset in the middle of a run
    issue(2'd2, 3'd3, 6'd1, 16'h0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule